// File: doc/BRIEF.md
# SDRAM Periodic Refresh Scheduler

This block keeps a synchronous DRAM's contents alive by producing auto-refresh commands at a steady rate. A free-running interval timer adds one owed refresh each time it expires. While at least one refresh is owed and no refresh sequence is in progress, the block raises a request toward the command arbiter. When the arbiter grants the bus, the block issues the commands itself. If any bank still has an open row, it first sends a precharge-all command, waits out the row precharge time, and then sends the auto-refresh command. If all banks are already closed, it sends the auto-refresh command at once. After the auto-refresh command it keeps a busy flag raised for the whole row cycle time, so the arbiter issues nothing to the memory in that window.

The arbiter may hold the grant back for some time. Up to eight owed refreshes are kept, and the block flags urgency once that backlog is full. The memory itself generates the row and bank addresses for each refresh, so this block only sequences the commands. All timing limits are given in picoseconds and the clock frequency in kilohertz. The block converts them to cycle counts when it is elaborated.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and after it is released, `req_o`, `busy_o` and `urgent_o` are low and `cmd_o` is NOP (2'b00). `req_o` stays low until the first interval has expired, which happens at the INTERVAL-th rising edge after reset is released.
- R2: The interval is floor(RETENTION_MS × CLK_KHZ / REFRESHES) clock cycles. With the defaults (64 ms, 200 MHz, 4096 refreshes) this is 3125 cycles. Each expiry adds one owed refresh. `req_o` is high exactly when at least one refresh is owed and `busy_o` is low.
- R3: When `grant_i` is high at a rising edge where `req_o` is high and `bank_open_i` is low, `cmd_o` shows auto-refresh (2'b10) for exactly the next cycle, and no precharge is sent.
- R4: When `grant_i` is high at a rising edge where `req_o` is high and `bank_open_i` is high, `cmd_o` shows precharge-all (2'b01) for exactly the next cycle. Auto-refresh then follows exactly TRP_CYC cycles after the precharge-all cycle.
- R5: `busy_o` rises in the cycle of the first command of a sequence. It stays high through the auto-refresh cycle and the TRC_CYC−1 cycles after it, so that a new command can follow the auto-refresh no sooner than TRC_CYC cycles later. `cmd_o` is NOP whenever `busy_o` is low, and `req_o` is low whenever `busy_o` is high.
- R6: At most MAX_OWED (8) owed refreshes are kept. Each auto-refresh retires one. An interval expiry that happens while the backlog is full is dropped.
- R7: `urgent_o` is high exactly when the backlog holds MAX_OWED owed refreshes.
- R8: `grant_i` has no effect when `req_o` is low: `cmd_o` stays NOP and `busy_o` stays low. Both `grant_i` and `bank_open_i` are ignored while `busy_o` is high.
- R9: TRP_CYC and TRC_CYC are the precharge and row cycle times divided by the clock period, rounded up. With the defaults (20 ns, 67.5 ns, 5 ns) they are 4 and 14 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all activity on its rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Arbiter hands the command bus to this block |
| bank_open_i | input | 1 | High when at least one bank has an open row |
| req_o | output | 1 | A refresh is owed and the block wants the bus |
| urgent_o | output | 1 | Backlog of owed refreshes is full |
| busy_o | output | 1 | A refresh sequence owns the bus; the arbiter must stay off it |
| cmd_o | output | 2 | Command to drive: 00 NOP, 01 precharge-all, 10 auto-refresh |

## Verification
On every cycle the assertions check that commands appear only while busy is high and that a request never coexists with busy. They also check that an accepted grant starts a sequence on the next cycle, that a refresh after precharge-all keeps exactly the precharge spacing, that nothing follows a refresh inside the row cycle window, and that a full backlog always asks for the bus. The exact interval length, the way expiries accumulate and saturate at eight, and the number of refreshes a backlog drains to can only be shown by the bench's scenarios. The bench compares every cycle against its own model and also measures these counts in directed runs that hold the grant back for many intervals.

// File: rtl/sdram_refresh_pkg.sv
// Shared types and elaboration-time helpers for the refresh scheduler.
// Assumes timing values in picoseconds and clock frequency in kilohertz.
package sdram_refresh_pkg;

    // Command encoding seen by the memory command path
    typedef enum logic [1:0] {
        RCMD_NOP  = 2'b00,
        RCMD_PREA = 2'b01,
        RCMD_REFA = 2'b10
    } rcmd_e;

    // Sequencer phases: idle, waiting out precharge, holding for row cycle
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'b00,
        SEQ_CLOSE = 2'b01,
        SEQ_HOLD  = 2'b10
    } seq_state_e;

    // Converts a duration in ps to whole clock cycles, rounded up
    function automatic int unsigned cycles_ceil(input longint unsigned dur_ps,
                                                input longint unsigned clk_khz);
        longint unsigned prod;
        prod = dur_ps * clk_khz;
        return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
    endfunction

    // Counter width able to hold values 0..n-1, never below one bit
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
// Free-running down-counter that pulses tick_o once every PERIOD cycles.
// Assumes PERIOD >= 1; the first pulse comes PERIOD edges after reset.
module refresh_interval_timer
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned PERIOD = 3125
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int unsigned W = bits_for(PERIOD);
    localparam logic [W-1:0] RELOAD = W'(PERIOD - 1);

    logic [W-1:0] cnt_q;

    // Counts down and reloads after reaching zero
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= RELOAD;
        end else if (cnt_q == '0) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry pulse is taken straight from the zero state
    always_comb begin
        tick_o = (cnt_q == '0);
    end

endmodule

// File: rtl/refresh_backlog.sv
// Saturating count of owed refreshes: +1 per interval tick, -1 per issued
// auto-refresh. Assumes retire_i is never raised while the count is zero.
module refresh_backlog
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned MAX_OWED = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic retire_i,
    output logic pending_o,
    output logic full_o
);
    localparam int unsigned W = bits_for(MAX_OWED + 1);
    localparam logic [W-1:0] LIMIT = W'(MAX_OWED);

    logic [W-1:0] owed_q;

    // Adds and retires owed refreshes, dropping ticks when full
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            owed_q <= '0;
        end else begin
            unique case ({tick_i, retire_i})
                2'b10: if (owed_q != LIMIT) owed_q <= owed_q + 1'b1;
                2'b01: if (owed_q != '0)    owed_q <= owed_q - 1'b1;
                default: owed_q <= owed_q;
            endcase
        end
    end

    // Status flags derived from the stored count
    always_comb begin
        pending_o = (owed_q != '0);
        full_o    = (owed_q == LIMIT);
    end

endmodule

// File: rtl/refresh_sequencer.sv
// Drives the precharge-all / auto-refresh sequence once the bus is granted
// and spaces commands by the precharge and row cycle times.
// Assumes the arbiter issues nothing to memory while busy_o is high.
module refresh_sequencer
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned TRP_CYC = 4,
    parameter int unsigned TRC_CYC = 14
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       pending_i,
    input  logic       grant_i,
    input  logic       bank_open_i,
    output logic       req_o,
    output logic       busy_o,
    output logic       retire_o,
    output logic [1:0] cmd_o
);
    localparam int unsigned SPAN = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int unsigned W = bits_for(SPAN);
    localparam logic [W-1:0] TRP_LOAD = W'((TRP_CYC > 0) ? TRP_CYC - 1 : 0);
    localparam logic [W-1:0] TRC_LOAD = W'((TRC_CYC > 0) ? TRC_CYC - 1 : 0);

    seq_state_e   state_q, state_d;
    logic [W-1:0] cnt_q, cnt_d;
    rcmd_e        cmd_q, cmd_d;
    logic         start;

    // Grant is accepted only while idle with a refresh owed
    always_comb begin
        start = (state_q == SEQ_IDLE) && pending_i && grant_i;
    end

    // Next-state, spacing counter and command selection
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        cmd_d    = RCMD_NOP;
        retire_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                if (start && bank_open_i) begin
                    state_d = SEQ_CLOSE;
                    cnt_d   = TRP_LOAD;
                    cmd_d   = RCMD_PREA;
                end else if (start) begin
                    state_d  = SEQ_HOLD;
                    cnt_d    = TRC_LOAD;
                    cmd_d    = RCMD_REFA;
                    retire_o = 1'b1;
                end
            end
            SEQ_CLOSE: begin
                if (cnt_q == '0) begin
                    state_d  = SEQ_HOLD;
                    cnt_d    = TRC_LOAD;
                    cmd_d    = RCMD_REFA;
                    retire_o = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = SEQ_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Registers state, counter and the one-cycle command
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            cmd_q   <= RCMD_NOP;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cmd_q   <= cmd_d;
        end
    end

    // Bus-facing outputs decoded from registered state
    always_comb begin
        busy_o = (state_q != SEQ_IDLE);
        req_o  = pending_i && (state_q == SEQ_IDLE);
        cmd_o  = cmd_q;
    end

endmodule

// File: rtl/sdram_refresh_sched.sv
// Top of the refresh scheduler: converts time limits to cycles and wires the
// interval timer, backlog counter and command sequencer together.
// Assumes clk_i runs at CLK_KHZ and the arbiter honours busy_o.
module sdram_refresh_sched
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned CLK_KHZ      = 200_000,
    parameter int unsigned RETENTION_MS = 64,
    parameter int unsigned REFRESHES    = 4096,
    parameter int unsigned TRP_PS       = 20_000,
    parameter int unsigned TRC_PS       = 67_500,
    parameter int unsigned MAX_OWED     = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       grant_i,
    input  logic       bank_open_i,
    output logic       req_o,
    output logic       urgent_o,
    output logic       busy_o,
    output logic [1:0] cmd_o
);
    localparam longint unsigned INTERVAL_L =
        (longint'(RETENTION_MS) * longint'(CLK_KHZ)) / longint'(REFRESHES);
    localparam int unsigned INTERVAL_CYC = (INTERVAL_L < 1) ? 1 : int'(INTERVAL_L);
    localparam int unsigned TRP_RAW = cycles_ceil(longint'(TRP_PS), longint'(CLK_KHZ));
    localparam int unsigned TRC_RAW = cycles_ceil(longint'(TRC_PS), longint'(CLK_KHZ));
    localparam int unsigned TRP_CYC = (TRP_RAW < 1) ? 1 : TRP_RAW;
    localparam int unsigned TRC_CYC = (TRC_RAW < 1) ? 1 : TRC_RAW;

    logic tick;
    logic retire;
    logic pending;

    refresh_interval_timer #(
        .PERIOD(INTERVAL_CYC)
    ) timer_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    refresh_backlog #(
        .MAX_OWED(MAX_OWED)
    ) backlog_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .retire_i (retire),
        .pending_o(pending),
        .full_o   (urgent_o)
    );

    refresh_sequencer #(
        .TRP_CYC(TRP_CYC),
        .TRC_CYC(TRC_CYC)
    ) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pending_i  (pending),
        .grant_i    (grant_i),
        .bank_open_i(bank_open_i),
        .req_o      (req_o),
        .busy_o     (busy_o),
        .retire_o   (retire),
        .cmd_o      (cmd_o)
    );

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
// Protocol checker bound to the refresh scheduler top. Tracks the distance
// since the last precharge-all and auto-refresh with saturating counters.
// Assumes cmd encoding 00 NOP, 01 precharge-all, 10 auto-refresh.
module sdram_refresh_sched_chk
    import sdram_refresh_pkg::*;
#(
    parameter int unsigned TRP_CYC = 4,
    parameter int unsigned TRC_CYC = 14
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       grant_i,
    input logic       bank_open_i,
    input logic       req_o,
    input logic       urgent_o,
    input logic       busy_o,
    input logic [1:0] cmd_o
);
    localparam int unsigned CAP = TRC_CYC + 2;
    localparam int unsigned W = bits_for(CAP + 1);
    localparam logic [W-1:0] CAP_V = W'(CAP);

    logic [W-1:0] since_pre_q, since_ref_q;
    logic         pre_pend_q, ref_seen_q;

    // Distance counters and sequence flags
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_pre_q <= '0;
            since_ref_q <= '0;
            pre_pend_q  <= 1'b0;
            ref_seen_q  <= 1'b0;
        end else begin
            if (cmd_o == RCMD_PREA)     since_pre_q <= W'(1);
            else if (since_pre_q < CAP_V) since_pre_q <= since_pre_q + 1'b1;
            if (cmd_o == RCMD_REFA)     since_ref_q <= W'(1);
            else if (since_ref_q < CAP_V) since_ref_q <= since_ref_q + 1'b1;
            if (cmd_o == RCMD_PREA)      pre_pend_q <= 1'b1;
            else if (cmd_o == RCMD_REFA) pre_pend_q <= 1'b0;
            if (cmd_o == RCMD_REFA)      ref_seen_q <= 1'b1;
        end
    end

    AST_CMD_NEEDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o != RCMD_NOP) |-> busy_o); // R5
    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !req_o); // R5
    AST_GRANT_STARTS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && grant_i) |=> (busy_o && cmd_o != RCMD_NOP)); // R3
    AST_DIRECT_REFRESH_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && grant_i && !bank_open_i) |=> (cmd_o == RCMD_REFA)); // R3
    AST_OPEN_GETS_PRECHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && grant_i && bank_open_i) |=> (cmd_o == RCMD_PREA)); // R4
    AST_PRECHARGE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == RCMD_REFA && pre_pend_q) |-> (since_pre_q == W'(TRP_CYC))); // R4
    AST_ROW_CYCLE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o != RCMD_NOP && ref_seen_q) |-> (since_ref_q >= W'(TRC_CYC))); // R5
    AST_IDLE_GRANT_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_o && !busy_o && grant_i) |=> !busy_o); // R8
    AST_URGENT_ASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (urgent_o && !busy_o) |-> req_o); // R7

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
    .TRP_CYC(TRP_CYC),
    .TRC_CYC(TRC_CYC)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant_i),
    .bank_open_i(bank_open_i),
    .req_o      (req_o),
    .urgent_o   (urgent_o),
    .busy_o     (busy_o),
    .cmd_o      (cmd_o)
);

// File: tb/sdram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: a cycle model built from the requirements is compared
// every cycle, plus directed runs for reset, saturation and spacing.
module sdram_refresh_sched_tb_top;

    // Expected constants, computed from the requirements at 200 MHz
    localparam int INT_EXP   = (64 * 200000) / 4096;          // R2: 3125
    localparam int TRP_EXP   = (20000 * 200 + 999999) / 1000000; // R9: 4
    localparam int TRC_EXP   = (67500 * 200 + 999999) / 1000000; // R9: 14
    localparam int OWED_MAX  = 8;
    localparam int WATCHDOG  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grant = 1'b0;
    logic       bank_open = 1'b0;
    logic       req, urgent, busy;
    logic [1:0] cmd;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit model_on = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdram_refresh_sched dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .grant_i    (grant),
        .bank_open_i(bank_open),
        .req_o      (req),
        .urgent_o   (urgent),
        .busy_o     (busy),
        .cmd_o      (cmd)
    );

    // ---------------- reference model ----------------
    int m_tmr, m_owed, m_state, m_cnt;
    logic [1:0] m_cmd;

    function automatic bit exp_req();
        return (m_owed > 0) && (m_state == 0);
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_tmr = 0; m_owed = 0; m_state = 0; m_cnt = 0; m_cmd = 2'b00;
        end else begin
            bit tick, ret;
            tick = (m_tmr == INT_EXP - 1);
            m_tmr = tick ? 0 : m_tmr + 1;
            ret = 1'b0;
            m_cmd = 2'b00;
            case (m_state)
                0: if (m_owed > 0 && grant) begin
                       if (bank_open) begin m_state = 1; m_cnt = TRP_EXP - 1; m_cmd = 2'b01; end
                       else begin m_state = 2; m_cnt = TRC_EXP - 1; m_cmd = 2'b10; ret = 1'b1; end
                   end
                1: if (m_cnt == 0) begin m_state = 2; m_cnt = TRC_EXP - 1; m_cmd = 2'b10; ret = 1'b1; end
                   else m_cnt = m_cnt - 1;
                default: if (m_cnt == 0) m_state = 0; else m_cnt = m_cnt - 1;
            endcase
            if (tick && !ret && m_owed < OWED_MAX) m_owed = m_owed + 1;
            else if (!tick && ret) m_owed = m_owed - 1;
        end
    end

    task automatic check(input bit ok, input string req_tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req_tag, what, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            check(req === exp_req(), "R2", "req", int'(req), int'(exp_req()));
            check(busy === (m_state != 0), "R5", "busy", int'(busy), int'(m_state != 0));
            check(urgent === (m_owed == OWED_MAX), "R7", "urgent", int'(urgent), int'(m_owed == OWED_MAX));
            check(cmd === m_cmd, "R3 R4", "cmd", int'(cmd), int'(m_cmd));
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int rise_at, prea_at, refa_at, fall_at, n_refa, n_prea, idx;
        void'($urandom(32'h5EED_1234));

        // R1: reset state
        wait_cycles(5);
        check(req == 1'b0 && busy == 1'b0 && urgent == 1'b0 && cmd == 2'b00,
              "R1", "outputs in reset", int'({req, busy, urgent, cmd}), 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R8: grant toggled while nothing is owed has no effect
        for (int i = 0; i < 100; i++) begin
            grant = 1'($urandom % 2);
            bank_open = 1'($urandom % 2);
            @(negedge clk);
            check(busy == 1'b0 && cmd == 2'b00, "R8", "grant without request",
                  int'({busy, cmd}), 0);
        end
        grant = 1'b0;

        // R1/R2: first request exactly one interval after reset release
        rise_at = -1;
        for (int i = 101; i <= INT_EXP + 5; i++) begin
            @(negedge clk);
            if (req && rise_at < 0) rise_at = i;
        end
        check(rise_at == INT_EXP, "R1", "first request edge", rise_at, INT_EXP);

        // R6/R7: withhold grant for ten intervals -> backlog saturates
        wait_cycles(INT_EXP * 9 + 20);
        check(urgent == 1'b1 && req == 1'b1, "R7", "urgent after saturation",
              int'({urgent, req}), 3);

        // Directed drain: first with an open bank, then closed
        grant = 1'b1; bank_open = 1'b1;
        prea_at = -1; refa_at = -1; fall_at = -1; n_refa = 0; n_prea = 0; idx = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            idx++;
            if (cmd == 2'b01) begin
                n_prea++;
                if (prea_at < 0) prea_at = idx;
                bank_open = 1'b0;
            end
            if (cmd == 2'b10) begin
                n_refa++;
                if (refa_at < 0) refa_at = idx;
            end
            if (refa_at >= 0 && fall_at < 0 && !busy) fall_at = idx;
            if (n_refa > 0 && !req && !busy) break;
        end
        check(refa_at - prea_at == TRP_EXP, "R4", "precharge to refresh gap", refa_at - prea_at, TRP_EXP);
        check(refa_at - prea_at == TRP_EXP, "R9", "rounded tRP cycles", refa_at - prea_at, TRP_EXP);
        check(fall_at - refa_at == TRC_EXP, "R5", "busy after refresh", fall_at - refa_at, TRC_EXP);
        check(fall_at - refa_at == TRC_EXP, "R9", "rounded tRC cycles", fall_at - refa_at, TRC_EXP);
        check(n_refa == OWED_MAX, "R6", "refreshes drained from full backlog", n_refa, OWED_MAX);
        check(n_prea == 1, "R3", "no precharge when banks closed", n_prea, 1);
        check(urgent == 1'b0, "R7", "urgent cleared after drain", int'(urgent), 0);

        // Constrained random segments: withheld, sparse and steady grants
        for (int s = 0; s < 10; s++) begin
            int mode, len;
            mode = int'($urandom % 3);
            len  = 3000 + int'($urandom % 4000);
            for (int i = 0; i < len; i++) begin
                case (mode)
                    0: grant = 1'b0;
                    1: grant = (($urandom % 5) == 0);
                    default: grant = 1'b1;
                endcase
                bank_open = 1'($urandom % 2);
                @(negedge clk);
            end
        end
        grant = 1'b0;
        wait_cycles(20);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule